// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Every branch that resolves feeds one shared outcome shift register, so the prediction for a branch depends both on its own address and on what the most recent branches anywhere in the program did. The direction is stored as a table of 2-bit saturating counters. Each counter is selected by an index made of low branch-address bits followed by the outcome history bits.

The front end presents a branch address on the lookup port and receives the predicted direction combinationally, in the same cycle. When the branch resolves later in the pipeline, the back end presents the same address and the real outcome on the update port. That trains one counter and shifts the outcome into the history. Entries carry no tag, so branches whose index bits match share a counter. Table size, address slice and history length are parameters.

Top module: `gh_predictor`

## Requirements
- R1: `lk_taken` is a combinational function of `lk_pc` and the current state. It is 1 exactly when the selected counter holds 2 or 3. Counters hold unsigned values from 0 to 3.
- R2: The counter index is `{pc[PC_LSB+PC_IDX_W-1:PC_LSB], history}`. The address slice forms the upper bits and the history forms the lower HIST_W bits. Defaults are PC_LSB=2, PC_IDX_W=4 and HIST_W=6.
- R3: An update with `upd_taken`=1 raises the selected counter by one. A counter at 3 stays at 3.
- R4: An update with `upd_taken`=0 lowers the selected counter by one. A counter at 0 stays at 0.
- R5: On each update clock edge the history shifts one place toward its MSB. The outcome (1 = taken) enters bit 0 and the oldest bit is dropped. Without an update the history holds, and lookups never change any state.
- R6: The update index is formed from `upd_pc` and the history as it was before this update's outcome is shifted in.
- R7: A lookup in the same cycle as an update returns the prediction from before that update, including when both select the same counter.
- R8: While `rst_n` is low, every counter is 1 and the history is 0, so every lookup predicts not-taken. Reset asserts asynchronously and releases on the second rising clock edge after `rst_n` rises.
- R9: Two addresses that differ only outside the index slice select the same counter and return the same prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Branch address to predict |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
A corrupted history shows up at the ports within one lookup. It shifts every later index, so predictions from trained entries appear at the wrong addresses in the cycle after the bad update. A counter that wraps instead of saturating shows up as a flipped prediction once the history returns to the same pattern. The bench arranges that return within six updates. A wrong update index, or a same-cycle lookup that sees the new value, changes `lk_taken` in the very cycle the counter is next read, and the reference model compares that cycle directly.

// File: rtl/gh_pkg.sv
package gh_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN     = 2'd0;
  localparam ctr_t CTR_WEAK_NT = 2'd1;
  localparam ctr_t CTR_MAX     = 2'd3;

  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? CTR_MAX : ctr_t'(cur + 2'd1);
    else       res = (cur == CTR_MIN) ? CTR_MIN : ctr_t'(cur - 2'd1);
    return res;
  endfunction

  function automatic logic ctr_says_taken(input ctr_t cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/gh_rst_sync.sv
module gh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;
endmodule

// File: rtl/gh_index.sv
module gh_index #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int PC_IDX_W = 4,
  parameter int HIST_W   = 6,
  localparam int IDX_W   = PC_IDX_W + HIST_W
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  // address slice in the upper bits, outcome history in the lower bits
  assign idx = {pc[PC_LSB +: PC_IDX_W], hist};
endmodule

// File: rtl/gh_history.sv
module gh_history #(
  parameter int HIST_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              outcome,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (shift_en) begin
      if (HIST_W > 1) hist_d = {hist_q[HIST_W-2:0], outcome};
      else            hist_d = outcome;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;

  a_r5_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));

  a_r5_newest_lsb: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(outcome));
endmodule

// File: rtl/gh_counter_table.sv
module gh_counter_table #(
  parameter int IDX_W  = 10,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output gh_pkg::ctr_t     rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);
  import gh_pkg::*;

  ctr_t mem [DEPTH];
  ctr_t wr_cur;
  ctr_t wr_next;

  assign rd_ctr = mem[rd_idx];
  assign wr_cur = mem[wr_idx];

  always_comb begin
    wr_next = ctr_train(wr_cur, wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_WEAK_NT;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_next;
    end
  end

  a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_cur == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);

  a_r4_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_cur == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);

  a_r3_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_cur != CTR_MAX) |=> mem[$past(wr_idx)] > $past(wr_cur));

  a_r4_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_cur != CTR_MIN) |=> mem[$past(wr_idx)] < $past(wr_cur));
endmodule

// File: rtl/gh_predictor.sv
module gh_predictor #(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int PC_IDX_W = 4,
  parameter int HIST_W   = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);
  import gh_pkg::*;

  localparam int IDX_W = PC_IDX_W + HIST_W;

  logic              rst_n_int;
  logic [HIST_W-1:0] hist;
  logic [IDX_W-1:0]  lk_idx;
  logic [IDX_W-1:0]  upd_idx;
  ctr_t              lk_ctr;

  gh_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  gh_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .shift_en (upd_valid),
    .outcome  (upd_taken),
    .hist     (hist)
  );

  gh_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_lk_idx (
    .pc   (lk_pc),
    .hist (hist),
    .idx  (lk_idx)
  );

  // history here is the value before this update is shifted in
  gh_index #(.PC_W(PC_W), .PC_LSB(PC_LSB), .PC_IDX_W(PC_IDX_W), .HIST_W(HIST_W)) u_upd_idx (
    .pc   (upd_pc),
    .hist (hist),
    .idx  (upd_idx)
  );

  gh_counter_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (upd_idx),
    .wr_taken (upd_taken)
  );

  assign lk_taken = ctr_says_taken(lk_ctr);

  a_r8_reset_nt: assert property (@(posedge clk)
    !rst_n_int |-> !lk_taken);
endmodule

// File: tb/gh_predictor_test.sv
module gh_predictor_test;
  localparam int PC_LSB = 2;
  localparam int PIW    = 4;
  localparam int HW     = 6;
  localparam int DEPTH  = 1 << (PIW + HW);

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_taken;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  int m_ctr [DEPTH];
  int m_hist;

  always #10 clk = ~clk;  // 50 MHz

  gh_predictor uut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken)
  );

  // stimulus vector: update valid, update pc, update outcome, lookup pc, expected prediction
  typedef struct packed {
    logic        uv;
    logic [31:0] upc;
    logic        ut;
    logic [31:0] lpc;
    logic        exp;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'h10, 1'b0, 32'h10, 1'b0},  // R8 fresh entry weak not-taken
    '{1'b1, 32'h10, 1'b1, 32'h10, 1'b0},  // R7 same entry, pre-update value
    '{1'b1, 32'h10, 1'b0, 32'h10, 1'b0},  // R2 history 1 picks another entry
    '{1'b1, 32'h20, 1'b0, 32'h10, 1'b0},
    '{1'b1, 32'h20, 1'b0, 32'h10, 1'b0},
    '{1'b1, 32'h20, 1'b0, 32'h10, 1'b0},
    '{1'b1, 32'h20, 1'b0, 32'h10, 1'b0},
    '{1'b1, 32'h20, 1'b0, 32'h10, 1'b0},  // history shifts back to zero (R5)
    '{1'b0, 32'h00, 1'b0, 32'h10, 1'b1},  // R1 trained entry now at 2
    '{1'b0, 32'h00, 1'b0, 32'h50, 1'b1}   // R9 alias of 0x10
  };

  function automatic int m_idx(input logic [31:0] pc);
    return (int'((pc >> PC_LSB) & ((1 << PIW) - 1)) << HW) | m_hist;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 1;
    m_hist = 0;
  endtask

  task automatic check(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: lk_taken=%0b expected %0b", rq, act, exp);
    end
  endtask

  // one cycle: drive, compare combinational prediction, advance model and clock
  task automatic step(input logic uv, input logic [31:0] upc, input logic ut,
                      input logic [31:0] lpc, input int exp_forced, input string rq);
    int li, ui;
    logic e;
    @(negedge clk);
    upd_valid = uv; upd_pc = upc; upd_taken = ut; lk_pc = lpc;
    #2;
    li = m_idx(lpc);
    e = (exp_forced >= 0) ? logic'(exp_forced[0]) : logic'(m_ctr[li] >= 2);
    check(rq, lk_taken, e);
    if (uv) begin
      ui = m_idx(upc);
      if (ut) m_ctr[ui] = (m_ctr[ui] == 3) ? 3 : m_ctr[ui] + 1;
      else    m_ctr[ui] = (m_ctr[ui] == 0) ? 0 : m_ctr[ui] - 1;
      m_hist = ((m_hist << 1) | int'(ut)) & ((1 << HW) - 1);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; upd_valid = 1'b0;
    m_reset();
    #2;
    check("R8 during reset", lk_taken, 1'b0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    m_reset();
    do_reset();

    for (int v = 0; v < NVEC; v++)
      step(VECS[v].uv, VECS[v].upc, VECS[v].ut, VECS[v].lpc, int'(VECS[v].exp), "R1 R2 R7 R9 table");

    // R3: saturate high with history all ones, then one decrement
    do_reset();
    for (int k = 0; k < 10; k++) step(1'b1, 32'h30, 1'b1, 32'h30, -1, "R3 train up");
    step(1'b1, 32'h30, 1'b0, 32'h30, 1, "R3 held at 3");
    for (int k = 0; k < 6; k++) step(1'b1, 32'h34, 1'b1, 32'h30, -1, "R5 refill");
    step(1'b0, 32'h0, 1'b0, 32'h30, 1, "R3 value 2 after saturation");

    // R4: saturate low with history all zeros, then one increment
    do_reset();
    for (int k = 0; k < 10; k++) step(1'b1, 32'h30, 1'b0, 32'h30, -1, "R4 train down");
    step(1'b1, 32'h30, 1'b1, 32'h30, 0, "R4 held at 0");
    for (int k = 0; k < 6; k++) step(1'b1, 32'h34, 1'b0, 32'h30, -1, "R5 drain");
    step(1'b0, 32'h0, 1'b0, 32'h30, 0, "R4 value 1 after saturation");
    step(1'b1, 32'h30, 1'b1, 32'h30, 0, "R6 pre-update index");
    step(1'b0, 32'h0, 1'b0, 32'h70, 0, "R9 alias after shift");

    // lookups alone leave state untouched
    for (int k = 0; k < 8; k++) step(1'b0, 32'h0, 1'b0, 32'(k * 4), -1, "R5 idle lookups");

    // pseudo-random mix against the model
    lfsr = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[1], {26'h0, lfsr[7:4], 2'b00}, lfsr[2] | lfsr[3],
           {24'h0, lfsr[15:8]}, -1, "R1 R2 R6 mixed");
    end

    // R8: reset after training clears counters
    for (int k = 0; k < 8; k++) step(1'b1, 32'h3C, 1'b1, 32'h3C, -1, "R3 pre-reset train");
    do_reset();
    step(1'b0, 32'h0, 1'b0, 32'h3C, 0, "R8 after reset");
    step(1'b1, 32'h3C, 1'b1, 32'h3C, 0, "R8 weak entry");
    step(1'b0, 32'h0, 1'b0, 32'h3C, 0, "R8 history cleared");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule